// File: doc/BRIEF.md
# Operand Effective Address Generator

This block produces the memory operand address for a small processor core. It serves two ways of naming an operand. In the first, an address register is stepped down by the operand size and then used as the address. In the second, an address carried in the instruction is widened to the full 32 bits. The block holds eight 32-bit address registers, which a separate port can load.

A request carries these inputs:
- the mode bit;
- the operand size;
- a 3-bit register index;
- a flag telling a program-address access from a data access;
- the absolute address field together with its width tag.

One clock later the block presents the 24-bit effective address, a valid pulse and a fault flag. For the stepping mode it also presents a write-back strobe, the register index and the full 32-bit new register value. The register is updated on the same edge.

Top module: `opnd_addr_gen`

## Requirements
- R1: With `am_abs`=0 the selected register is decremented by 1, 2 or 4 for `size` 00 (byte), 01 (word) and 10 or 11 (longword), and the decremented value is the effective address.
- R2: A decrement request sets `wb_en` together with `ea_vld`, presents the index and the full 32-bit decremented value on `wb_idx`/`wb_data`, and stores that value in the register so that the next request sees it. Absolute requests leave `wb_en` low.
- R3: For word or longword size, `fault` is set when bit 0 of the computed address is 1, in either mode. The register write-back still takes place.
- R4: With `am_abs`=1 and `abs_w`=00 (8-bit) on a data access, all upper bits are forced to one, so the address lies in FFFF00..FFFFFF.
- R5: With `abs_w`=01 (16-bit) on a data access, bit 15 is sign-extended. 0000..7FFF maps to 000000..007FFF and 8000..FFFF maps to FF8000..FFFFFF.
- R6: With `abs_w`=10 (24-bit) and `is_prog`=1, the upper 8 bits are zero-filled. The same tag on a data access sets `fault`.
- R7: With `is_prog`=1, the 8-bit and 16-bit tags set `fault`.
- R8: With `abs_w`=11 (32-bit), the field passes through unchanged. `ea` is always the low 24 bits of the 32-bit result.
- R9: `ea_vld` is high for exactly the cycle after each cycle in which `req` is high, and low otherwise.
- R10: If a load (`ld_en`) targets the same register as a decrement write-back in the same cycle, the loaded value wins. A decrement reads the register value from before that load.
- R11: After reset `ea_vld`, `fault` and `wb_en` are low and every register holds zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Request strobe |
| am_abs | input | 1 | 0 = register decrement, 1 = absolute |
| is_prog | input | 1 | Access is a program-instruction address |
| size | input | 2 | Operand size code |
| reg_idx | input | 3 | Address register selector |
| abs_addr | input | 32 | Absolute address field |
| abs_w | input | 2 | Absolute width tag: 00=8, 01=16, 10=24, 11=32 |
| ld_en | input | 1 | Register load strobe |
| ld_idx | input | 3 | Register load index |
| ld_data | input | 32 | Register load value |
| ea | output | 24 | Effective address |
| ea_vld | output | 1 | Result valid pulse |
| fault | output | 1 | Alignment or width-tag fault |
| wb_en | output | 1 | Register write-back strobe |
| wb_idx | output | 3 | Write-back register index |
| wb_data | output | 32 | Write-back register value |

## Verification
The hardest case to reach from the ports is a load and a decrement write-back that hit the same register on the same edge. The bench loads a known value, then issues a decrement request on that register while the load port writes a different value to it in the same cycle. It checks that the address comes from the old value. A second decrement request then reveals which value the register kept. A misaligned word decrement is followed by a byte decrement in the same way, which proves that the faulting write-back was stored.

// File: rtl/opnd_addr_gen.sv
module opnd_addr_gen #(
  parameter int AW   = 32,
  parameter int EAW  = 24,
  parameter int NREG = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req,
  input  logic                    am_abs,
  input  logic                    is_prog,
  input  logic [1:0]              size,
  input  logic [$clog2(NREG)-1:0] reg_idx,
  input  logic [AW-1:0]           abs_addr,
  input  logic [1:0]              abs_w,
  input  logic                    ld_en,
  input  logic [$clog2(NREG)-1:0] ld_idx,
  input  logic [AW-1:0]           ld_data,
  output logic [EAW-1:0]          ea,
  output logic                    ea_vld,
  output logic                    fault,
  output logic                    wb_en,
  output logic [$clog2(NREG)-1:0] wb_idx,
  output logic [AW-1:0]           wb_data
);
  localparam int RIW = $clog2(NREG);

  logic [AW-1:0] rf [NREG];
  logic [AW-1:0] step, dec, wide, res;
  logic          tag_bad, mis, do_wb;

  always_comb begin
    case (size)
      2'b00:   step = AW'(1);
      2'b01:   step = AW'(2);
      default: step = AW'(4);
    endcase
  end

  assign dec = rf[reg_idx] - step;

  always_comb begin
    case (abs_w)
      2'b00:   wide = {{(AW-8){1'b1}}, abs_addr[7:0]};
      2'b01:   wide = {{(AW-16){abs_addr[15]}}, abs_addr[15:0]};
      2'b10:   wide = {{(AW-24){1'b0}}, abs_addr[23:0]};
      default: wide = abs_addr;
    endcase
  end

  assign res     = am_abs ? wide : dec;
  assign tag_bad = am_abs && (is_prog ? !abs_w[1] : (abs_w == 2'b10));
  assign mis     = (size != 2'b00) && res[0];
  assign do_wb   = req && !am_abs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else begin
      if (do_wb) rf[reg_idx] <= dec;
      if (ld_en) rf[ld_idx]  <= ld_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ea      <= '0;
      ea_vld  <= 1'b0;
      fault   <= 1'b0;
      wb_en   <= 1'b0;
      wb_idx  <= '0;
      wb_data <= '0;
    end else begin
      ea_vld <= req;
      wb_en  <= do_wb;
      if (req) begin
        ea      <= res[EAW-1:0];
        fault   <= tag_bad || mis;
        wb_idx  <= reg_idx;
        wb_data <= dec;
      end else begin
        fault <= 1'b0;
      end
    end
  end

  logic [RIW-1:0] unused_w;
  assign unused_w = wb_idx;
endmodule

// File: rtl/opnd_addr_gen_chk.sv
module opnd_addr_gen_chk #(
  parameter int AW  = 32,
  parameter int EAW = 24
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req,
  input logic           am_abs,
  input logic           is_prog,
  input logic [1:0]     abs_w,
  input logic [AW-1:0]  abs_addr,
  input logic [EAW-1:0] ea,
  input logic           ea_vld,
  input logic           fault,
  input logic           wb_en,
  input logic [AW-1:0]  wb_data
);
  p_vld_after_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> ea_vld);
  p_vld_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !ea_vld);
  p_wb_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (ea_vld && wb_data[EAW-1:0] == ea));
  p_abs_no_wb_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req && am_abs) |=> !wb_en);
  p_abs8_ones_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req && am_abs && !is_prog && abs_w == 2'b00) |=> (ea[EAW-1:8] == '1));
  p_abs16_sext_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req && am_abs && !is_prog && abs_w == 2'b01) |=>
      (ea == {{(EAW-16){$past(abs_addr[15])}}, $past(abs_addr[15:0])}));
  p_data24_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req && am_abs && !is_prog && abs_w == 2'b10) |=> fault);
  p_prog_short_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req && am_abs && is_prog && !abs_w[1]) |=> fault);
endmodule

bind opnd_addr_gen opnd_addr_gen_chk #(.AW(AW), .EAW(EAW)) u_chk (.*);

// File: tb/tb_opnd_addr_gen.sv
module tb_opnd_addr_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, am_abs = 1'b0, is_prog = 1'b0;
  logic [1:0]  size = 2'b00, abs_w = 2'b00;
  logic [2:0]  reg_idx = '0, ld_idx = '0, wb_idx;
  logic [31:0] abs_addr = '0, ld_data = '0, wb_data;
  logic        ld_en = 1'b0;
  logic [23:0] ea;
  logic        ea_vld, fault, wb_en;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  opnd_addr_gen dut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load(logic [2:0] idx, logic [31:0] v);
    @(negedge clk);
    ld_en = 1'b1; ld_idx = idx; ld_data = v;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic predec(logic [2:0] idx, logic [1:0] sz);
    @(negedge clk);
    req = 1'b1; am_abs = 1'b0; is_prog = 1'b0; size = sz; reg_idx = idx;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic absreq(logic prog, logic [1:0] w, logic [31:0] a, logic [1:0] sz);
    @(negedge clk);
    req = 1'b1; am_abs = 1'b1; is_prog = prog; abs_w = w; abs_addr = a; size = sz;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 ea_vld", 32'(ea_vld), 0);
    chk("R11 fault", 32'(fault), 0);
    chk("R11 wb_en", 32'(wb_en), 0);
    predec(3'd5, 2'b00);
    chk("R11 reg zero", wb_data, 32'hFFFF_FFFF);
  endtask

  task automatic t_predec();
    load(3'd2, 32'h0000_2000);
    predec(3'd2, 2'b10);
    chk("R1 long ea", 32'(ea), 32'h001FFC);
    chk("R2 wb_en", 32'(wb_en), 1);
    chk("R2 wb_idx", 32'(wb_idx), 2);
    predec(3'd2, 2'b01);
    chk("R1 word ea", 32'(ea), 32'h001FFA);
    chk("R1 word fault", 32'(fault), 0);
    predec(3'd2, 2'b00);
    chk("R1 byte ea", 32'(ea), 32'h001FF9);
    chk("R2 wb_data", wb_data, 32'h0000_1FF9);
    predec(3'd2, 2'b11);
    chk("R1 size11 ea", 32'(ea), 32'h001FF5);
  endtask

  task automatic t_pulse();
    predec(3'd0, 2'b00);
    chk("R9 vld high", 32'(ea_vld), 1);
    @(negedge clk);
    chk("R9 vld low", 32'(ea_vld), 0);
    chk("R9 wb low", 32'(wb_en), 0);
  endtask

  task automatic t_align();
    load(3'd3, 32'h0000_1001);
    predec(3'd3, 2'b01);
    chk("R3 fault", 32'(fault), 1);
    chk("R3 wb_en", 32'(wb_en), 1);
    predec(3'd3, 2'b00);
    chk("R3 wb kept", 32'(ea), 32'h000FFE);
    chk("R3 byte nofault", 32'(fault), 0);
    absreq(1'b0, 2'b11, 32'h0000_0101, 2'b01);
    chk("R3 abs odd word", 32'(fault), 1);
  endtask

  task automatic t_abs8();
    absreq(1'b0, 2'b00, 32'h1234_5678, 2'b00);
    chk("R4 ea", 32'(ea), 32'hFFFF78);
    chk("R4 fault", 32'(fault), 0);
    chk("R2 abs no wb", 32'(wb_en), 0);
  endtask

  task automatic t_abs16();
    absreq(1'b0, 2'b01, 32'h0000_7ABC, 2'b00);
    chk("R5 pos", 32'(ea), 32'h007ABC);
    absreq(1'b0, 2'b01, 32'hAAAA_8123, 2'b00);
    chk("R5 neg", 32'(ea), 32'hFF8123);
  endtask

  task automatic t_abs24();
    absreq(1'b1, 2'b10, 32'hAB12_3456, 2'b00);
    chk("R6 prog ea", 32'(ea), 32'h123456);
    chk("R6 prog ok", 32'(fault), 0);
    absreq(1'b0, 2'b10, 32'h0012_3456, 2'b00);
    chk("R6 data fault", 32'(fault), 1);
  endtask

  task automatic t_prog_short();
    absreq(1'b1, 2'b00, 32'h0000_0010, 2'b00);
    chk("R7 prog8 fault", 32'(fault), 1);
    absreq(1'b1, 2'b01, 32'h0000_0010, 2'b00);
    chk("R7 prog16 fault", 32'(fault), 1);
  endtask

  task automatic t_abs32();
    absreq(1'b0, 2'b11, 32'h55AB_CDEF, 2'b00);
    chk("R8 ea low24", 32'(ea), 32'hABCDEF);
    chk("R8 fault", 32'(fault), 0);
  endtask

  task automatic t_ld_prio();
    load(3'd4, 32'h0000_0500);
    @(negedge clk);
    req = 1'b1; am_abs = 1'b0; size = 2'b00; reg_idx = 3'd4;
    ld_en = 1'b1; ld_idx = 3'd4; ld_data = 32'h0000_0900;
    @(negedge clk);
    req = 1'b0; ld_en = 1'b0;
    chk("R10 old read", 32'(ea), 32'h0004FF);
    predec(3'd4, 2'b00);
    chk("R10 load wins", 32'(ea), 32'h0008FF);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_predec();
        t_pulse();
        t_align();
        t_abs8();
        t_abs16();
        t_abs24();
        t_prog_short();
        t_abs32();
        t_ld_prio();
      end
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule